// File: doc/BRIEF.md
# Two-Wire Register Slave with Switchable Device Address

This block sits between a two-wire serial bus (I2C-style, open-drain SCL and SDA) and the parallel register file of a peripheral. Both bus lines are brought into a faster system clock through synchronizers. START and STOP conditions are decoded in that clock. Register words are 16 bits wide and sit behind an 8-bit register address. A master writes a register address followed by one or more words. It reads a word back by sending a repeated START and then the read address.

The device answers to one of two 7-bit addresses. A select bit in the peripheral's own register space chooses between them. A STANDBY input freezes that select bit against writes, and every other bit and register is still written. Two identical devices sharing one bus therefore start on the same address. One broadcast write, sent while only one of them is in standby, moves the other device to the alternate address.

A small page register widens the register space. The block holds it itself and presents it beside each register-bus access.

Top module: `twi_regslave`

## Requirements
- R1: After reset, the SDA pull-down enable is low, no register-bus write strobe is active and the page output is 0.
- R2: After reset the block acknowledges device address 7'h5D (address byte 0xBA to write, 0xBB to read) and leaves device address 7'h48 unacknowledged.
- R3: A write of 1 to bit 10 of register 8'h0D on page 0, with STANDBY low, makes the block acknowledge only 7'h48 (0x90 to write, 0x91 to read) in all later transactions. Reading register 8'h0D then returns bit 10 as 1.
- R4: While STANDBY is high, a write to register 8'h0D leaves bit 10 at its current value. The other 15 bits reach the register bus unchanged.
- R5: A write transaction is sent as the address byte with bit 0 = 0, then the register-address byte, then a high byte and a low byte. It produces exactly one single-cycle bus write strobe, with bus_addr set to the register address and bus_wdata set to {high, low}.
- R6: Further byte pairs in the same write transaction go to consecutive register addresses, with one single-cycle strobe per completed word.
- R7: After a repeated START and the address byte with bit 0 = 1, the block sends the high byte and then the low byte of the addressed register, MSB first. When the master leaves SDA high on the acknowledge clock, the block releases SDA until the next START or STOP.
- R8: Register 8'hF0 holds the 3-bit page, taken from the low bits of the written word. Any page of the register space can reach it. Writes to it produce no bus strobe, its value drives bus_page, and a read of it returns the page zero-extended.
- R9: A START or STOP in the middle of a byte discards the partial byte and produces no register write. The next transaction works normally.
- R10: The block drives SDA only as open drain (an enable that pulls the line low) and changes that enable only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby | input | 1 | Blocks writes to the address-select bit |
| scl_in | input | 1 | Serial clock line as seen on the pad |
| sda_in | input | 1 | Serial data line as seen on the pad |
| sda_oe | output | 1 | High pulls SDA low; low releases it |
| bus_page | output | PAGE_W | Current page prefix |
| bus_addr | output | 8 | Register address for read and write |
| bus_wdata | output | 16 | Write data, valid with bus_we |
| bus_we | output | 1 | Single-cycle register write strobe |
| bus_rdata | input | 16 | Register read data for bus_page and bus_addr |

## Verification
The bench builds the block with its default parameters: two synchronizer stages, device addresses 7'h5D and 7'h48, select register 8'h0D bit 10, and page register 8'hF0 three bits wide. With these values the full standby-split sequence is reachable. Select bit 10 carries a 1 in the test word, so both outcomes of the write mask can be seen. Page 5 exercises a nonzero upper page bit. The default two-stage synchronizer keeps edge latency at three clocks. That latency is well inside the bench's quarter-bit spacing, so STARTs and STOPs placed in the middle of a byte are decoded without ambiguity.

// File: rtl/twi_pkg.sv
package twi_pkg;
   localparam int BYTE_W = 8;
   localparam int WORD_W = 16;
   localparam int CNT_W  = 4;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DEV,
      ST_REG,
      ST_WR,
      ST_RD,
      ST_WAIT
   } twi_state_e;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
   parameter int STAGES = 2,
   parameter int LINES  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] din,
   output logic [LINES-1:0] dout
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("twi_line_sync: STAGES must be at least 2");
      end
   endgenerate

   for (genvar l = 0; l < LINES; l++) begin : g_line
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '1;
         else        chain <= {chain[STAGES-2:0], din[l]};
      end
      assign dout[l] = chain[STAGES-1];
   end
endmodule

// File: rtl/twi_reg_map.sv
module twi_reg_map
   import twi_pkg::*;
#(
   parameter logic [6:0]        DEV_DEF  = 7'h5D,
   parameter logic [6:0]        DEV_ALT  = 7'h48,
   parameter logic [BYTE_W-1:0] SEL_REG  = 8'h0D,
   parameter int                SEL_BIT  = 10,
   parameter logic [BYTE_W-1:0] PAGE_REG = 8'hF0,
   parameter int                PAGE_W   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              standby,
   input  logic              commit,
   input  logic [BYTE_W-1:0] commit_addr,
   input  logic [WORD_W-1:0] commit_data,
   input  logic [BYTE_W-1:0] rd_addr,
   input  logic [WORD_W-1:0] bus_rdata,
   input  logic [6:0]        dev_addr,
   output logic              dev_match,
   output logic [PAGE_W-1:0] page,
   output logic              fwd,
   output logic [WORD_W-1:0] fwd_data,
   output logic [WORD_W-1:0] rd_value
);
   generate
      if (SEL_BIT < 0 || SEL_BIT >= WORD_W) begin : g_bad_bit
         $error("twi_reg_map: SEL_BIT outside the data word");
      end
      if (PAGE_W < 1 || PAGE_W > WORD_W) begin : g_bad_page
         $error("twi_reg_map: PAGE_W out of range");
      end
      if (DEV_DEF == DEV_ALT) begin : g_bad_dev
         $error("twi_reg_map: device addresses must differ");
      end
   endgenerate

   logic alt_sel;
   logic page_hit;
   logic sel_hit_w;
   logic sel_hit_r;

   assign page_hit  = (commit_addr == PAGE_REG);
   assign sel_hit_w = (commit_addr == SEL_REG) && (page == '0);
   assign sel_hit_r = (rd_addr == SEL_REG) && (page == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         alt_sel <= 1'b0;
         page    <= '0;
      end else if (commit) begin
         if (page_hit)               page    <= commit_data[PAGE_W-1:0];
         if (sel_hit_w && !standby)  alt_sel <= commit_data[SEL_BIT];
      end
   end

   assign fwd       = commit && !page_hit;
   assign dev_match = (dev_addr == (alt_sel ? DEV_ALT : DEV_DEF));

   always_comb begin
      fwd_data = commit_data;
      if (sel_hit_w && standby) fwd_data[SEL_BIT] = alt_sel;
   end

   always_comb begin
      rd_value = bus_rdata;
      if (rd_addr == PAGE_REG) begin
         rd_value              = '0;
         rd_value[PAGE_W-1:0]  = page;
      end else if (sel_hit_r) begin
         rd_value[SEL_BIT] = alt_sel;
      end
   end

   // R4
   sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(alt_sel) |-> $past(!standby && commit));

   // R8
   page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(page) |-> $past(commit && commit_addr == PAGE_REG));
endmodule

// File: rtl/twi_regslave.sv
module twi_regslave
   import twi_pkg::*;
#(
   parameter int                SYNC_STAGES = 2,
   parameter logic [6:0]        DEV_DEF     = 7'h5D,
   parameter logic [6:0]        DEV_ALT     = 7'h48,
   parameter logic [BYTE_W-1:0] SEL_REG     = 8'h0D,
   parameter int                SEL_BIT     = 10,
   parameter logic [BYTE_W-1:0] PAGE_REG    = 8'hF0,
   parameter int                PAGE_W      = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              standby,
   input  logic              scl_in,
   input  logic              sda_in,
   output logic              sda_oe,
   output logic [PAGE_W-1:0] bus_page,
   output logic [BYTE_W-1:0] bus_addr,
   output logic [WORD_W-1:0] bus_wdata,
   output logic              bus_we,
   input  logic [WORD_W-1:0] bus_rdata
);
   localparam logic [CNT_W-1:0] CNT_ACK  = CNT_W'(BYTE_W);
   localparam logic [CNT_W-1:0] CNT_DONE = CNT_W'(BYTE_W + 1);

   logic [1:0] lines_s;
   logic       scl_hi, sda_hi, scl_q, sda_q;
   logic       scl_rise, scl_fall, start_det, stop_det;

   twi_line_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
      .clk (clk), .rst_n (rst_n),
      .din ({scl_in, sda_in}), .dout (lines_s)
   );
   assign scl_hi = lines_s[1];
   assign sda_hi = lines_s[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_hi;
         sda_q <= sda_hi;
      end
   end

   assign scl_rise  = scl_hi && !scl_q;
   assign scl_fall  = !scl_hi && scl_q;
   assign start_det = scl_hi && scl_q && sda_q && !sda_hi;
   assign stop_det  = scl_hi && scl_q && !sda_q && sda_hi;

   twi_state_e        st;
   logic [CNT_W-1:0]  cnt;
   logic [BYTE_W-1:0] sh, txb, hi_byte, reg_ptr;
   logic [WORD_W-1:0] rword;
   logic              half, rw;
   logic [2:0]        bidx;

   logic              commit, dev_match, fwd;
   logic [WORD_W-1:0] fwd_data, rd_value;

   assign commit = !start_det && !stop_det && (st == ST_WR) && scl_fall
                   && (cnt == CNT_ACK) && half;
   assign bidx   = 3'd7 - cnt[2:0];

   twi_reg_map #(
      .DEV_DEF (DEV_DEF), .DEV_ALT (DEV_ALT), .SEL_REG (SEL_REG),
      .SEL_BIT (SEL_BIT), .PAGE_REG (PAGE_REG), .PAGE_W (PAGE_W)
   ) u_map (
      .clk (clk), .rst_n (rst_n), .standby (standby),
      .commit (commit), .commit_addr (reg_ptr), .commit_data ({hi_byte, sh}),
      .rd_addr (reg_ptr), .bus_rdata (bus_rdata), .dev_addr (sh[7:1]),
      .dev_match (dev_match), .page (bus_page), .fwd (fwd),
      .fwd_data (fwd_data), .rd_value (rd_value)
   );

   assign bus_addr = reg_ptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= ST_IDLE;  cnt <= '0;      sh <= '0;     txb <= '0;
         hi_byte <= '0;  reg_ptr <= '0;  rword <= '0;  half <= 1'b0;
         rw <= 1'b0;     sda_oe <= 1'b0; bus_we <= 1'b0; bus_wdata <= '0;
      end else begin
         bus_we <= 1'b0;
         if (start_det) begin
            st <= ST_DEV;  cnt <= '0;  sda_oe <= 1'b0;
         end else if (stop_det) begin
            st <= ST_IDLE; cnt <= '0;  sda_oe <= 1'b0;
         end else if (st == ST_DEV || st == ST_REG || st == ST_WR) begin
            if (scl_rise && cnt < CNT_ACK) begin
               sh  <= {sh[BYTE_W-2:0], sda_hi};
               cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == CNT_ACK) begin
               cnt <= CNT_DONE;
               case (st)
                  ST_DEV: begin
                     if (dev_match) begin
                        sda_oe <= 1'b1;
                        rw     <= sh[0];
                     end else begin
                        st <= ST_WAIT;
                     end
                  end
                  ST_REG: begin
                     sda_oe  <= 1'b1;
                     reg_ptr <= sh;
                     half    <= 1'b0;
                  end
                  default: begin
                     sda_oe <= 1'b1;
                     if (!half) begin
                        hi_byte <= sh;
                        half    <= 1'b1;
                     end else begin
                        bus_we    <= fwd;
                        bus_wdata <= fwd_data;
                        half      <= 1'b0;
                     end
                  end
               endcase
            end else if (scl_fall && cnt == CNT_DONE) begin
               sda_oe <= 1'b0;
               cnt    <= '0;
               case (st)
                  ST_DEV: begin
                     if (rw) begin
                        st     <= ST_RD;
                        half   <= 1'b0;
                        rword  <= rd_value;
                        txb    <= rd_value[WORD_W-1:BYTE_W];
                        sda_oe <= !rd_value[WORD_W-1];
                     end else begin
                        st <= ST_REG;
                     end
                  end
                  ST_REG:  st <= ST_WR;
                  default: if (!half) reg_ptr <= reg_ptr + 1'b1;
               endcase
            end
         end else if (st == ST_RD) begin
            if (scl_rise) begin
               if (cnt < CNT_ACK)                cnt <= cnt + 1'b1;
               else if (cnt == CNT_DONE && sda_hi) st <= ST_WAIT;
            end else if (scl_fall) begin
               if (cnt >= 1 && cnt < CNT_ACK) begin
                  sda_oe <= !txb[bidx];
               end else if (cnt == CNT_ACK) begin
                  sda_oe <= 1'b0;
                  cnt    <= CNT_DONE;
               end else if (cnt == CNT_DONE) begin
                  cnt <= '0;
                  if (!half) begin
                     half    <= 1'b1;
                     txb     <= rword[BYTE_W-1:0];
                     sda_oe  <= !rword[BYTE_W-1];
                     reg_ptr <= reg_ptr + 1'b1;
                  end else begin
                     half   <= 1'b0;
                     rword  <= rd_value;
                     txb    <= rd_value[WORD_W-1:BYTE_W];
                     sda_oe <= !rd_value[WORD_W-1];
                  end
               end
            end
         end
      end
   end

   // R10
   oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !$past(scl_hi));

   // R5
   we_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_we |-> (st == ST_WR));

   // R6
   we_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_we |=> !bus_we);

   // R7
   wait_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WAIT) |-> !sda_oe);
endmodule

// File: tb/tb_twi_regslave.sv
module tb_twi_regslave;
   localparam int Q = 8;
   localparam logic [6:0] DEF = 7'h5D;
   localparam logic [6:0] ALT = 7'h48;
   localparam logic [23:0] VEC [0:5] = '{
      24'h00_FFFF, 24'h01_0001, 24'h7F_8000,
      24'h80_A55A, 24'hFE_1234, 24'h55_7E81
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        standby = 1'b0;
   logic        scl_m = 1'b1;
   logic        sda_m = 1'b1;
   logic        sda_oe, bus_we;
   logic [2:0]  bus_page;
   logic [7:0]  bus_addr;
   logic [15:0] bus_wdata, bus_rdata;
   logic        sda_line;
   logic [15:0] mem [0:255];
   logic [2:0]  last_page = '0;
   int          we_cnt = 0;
   int          checks = 0;
   int          errors = 0;

   always #5 clk = ~clk;

   assign sda_line  = sda_m & ~sda_oe;
   assign bus_rdata = mem[bus_addr];

   initial for (int i = 0; i < 256; i++) mem[i] = 16'h0000;

   always @(posedge clk) begin
      if (bus_we) begin
         mem[bus_addr] <= bus_wdata;
         last_page     <= bus_page;
         we_cnt        <= we_cnt + 1;
      end
   end

   twi_regslave dut (
      .clk (clk), .rst_n (rst_n), .standby (standby),
      .scl_in (scl_m), .sda_in (sda_line), .sda_oe (sda_oe),
      .bus_page (bus_page), .bus_addr (bus_addr), .bus_wdata (bus_wdata),
      .bus_we (bus_we), .bus_rdata (bus_rdata)
   );

   task automatic chk(input logic ok, input string tag,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic wq();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
   endtask

   task automatic send_bits(input logic [7:0] b, input int n);
      for (int i = 7; i > 7 - n; i--) begin
         sda_m = b[i]; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
      end
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      send_bits(b, 8);
      sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); ack = ~sda_line; wq(); scl_m = 1'b0; wq();
   endtask

   task automatic recv_byte(output logic [7:0] b, input logic mack);
      for (int i = 7; i >= 0; i--) begin
         wq(); scl_m = 1'b1; wq(); b[i] = sda_line; wq(); scl_m = 1'b0;
      end
      wq(); sda_m = ~mack; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq(); sda_m = 1'b1;
   endtask

   task automatic write_word(input logic [6:0] dev, input logic [7:0] ra,
                             input logic [15:0] d, output logic ok);
      logic a0, a1, a2, a3;
      bus_start();
      send_byte({dev, 1'b0}, a0);
      send_byte(ra, a1);
      send_byte(d[15:8], a2);
      send_byte(d[7:0], a3);
      bus_stop();
      ok = a0 & a1 & a2 & a3;
   endtask

   task automatic read_word(input logic [6:0] dev, input logic [7:0] ra,
                            output logic [15:0] d, output logic ok);
      logic a0, a1, a2;
      logic [7:0] hb, lb;
      bus_start();
      send_byte({dev, 1'b0}, a0);
      send_byte(ra, a1);
      bus_start();
      send_byte({dev, 1'b1}, a2);
      recv_byte(hb, 1'b1);
      recv_byte(lb, 1'b0);
      wq();
      // R7: released after master no-acknowledge
      chk(sda_oe == 1'b0, "R7 release after nack", {31'b0, sda_oe}, 32'h0);
      bus_stop();
      d  = {hb, lb};
      ok = a0 & a1 & a2;
   endtask

   task automatic probe(input logic [6:0] dev, output logic ack);
      bus_start();
      send_byte({dev, 1'b0}, ack);
      bus_stop();
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog act=%h exp=%h", 32'h1, 32'h0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic ok, ack;
      logic [15:0] d;
      int n0;

      repeat (5) @(negedge clk);
      // R1: reset state
      chk(sda_oe == 1'b0, "R1 sda_oe", {31'b0, sda_oe}, 32'h0);
      chk(bus_we == 1'b0, "R1 bus_we", {31'b0, bus_we}, 32'h0);
      chk(bus_page == 3'd0, "R1 page", {29'b0, bus_page}, 32'h0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // R2: alternate address ignored, default answered
      probe(ALT, ack);
      chk(ack == 1'b0, "R2 alt nack", {31'b0, ack}, 32'h0);
      probe(DEF, ack);
      chk(ack == 1'b1, "R2 def ack", {31'b0, ack}, 32'h1);

      // R5 / R7: vector table
      for (int i = 0; i < 6; i++) begin
         n0 = we_cnt;
         write_word(DEF, VEC[i][23:16], VEC[i][15:0], ok);
         chk(ok, "R5 write acks", {31'b0, ok}, 32'h1);
         chk(we_cnt == n0 + 1, "R5 one strobe", we_cnt, n0 + 1);
         chk(mem[VEC[i][23:16]] == VEC[i][15:0], "R5 bus data",
             {16'b0, mem[VEC[i][23:16]]}, {16'b0, VEC[i][15:0]});
      end
      for (int i = 0; i < 6; i++) begin
         read_word(DEF, VEC[i][23:16], d, ok);
         chk(ok && d == VEC[i][15:0], "R7 readback", {15'b0, ok, d}, {16'h1, VEC[i][15:0]});
      end

      // R6: two words in one transaction
      begin
         logic a0, a1, a2, a3, a4, a5;
         n0 = we_cnt;
         bus_start();
         send_byte({DEF, 1'b0}, a0); send_byte(8'h40, a1);
         send_byte(8'h11, a2); send_byte(8'h22, a3);
         send_byte(8'h33, a4); send_byte(8'h44, a5);
         bus_stop();
         chk(a0 & a1 & a2 & a3 & a4 & a5, "R6 acks", 32'h0, 32'h1);
         chk(we_cnt == n0 + 2, "R6 two strobes", we_cnt, n0 + 2);
         read_word(DEF, 8'h40, d, ok);
         chk(d == 16'h1122, "R6 word0", {16'b0, d}, 32'h1122);
         read_word(DEF, 8'h41, d, ok);
         chk(d == 16'h3344, "R6 word1", {16'b0, d}, 32'h3344);
      end

      // R9: STOP inside register-address byte, START inside data byte
      n0 = we_cnt;
      bus_start();
      send_byte({DEF, 1'b0}, ack);
      send_bits(8'h01, 3);
      bus_stop();
      chk(we_cnt == n0, "R9 stop no write", we_cnt, n0);
      bus_start();
      send_byte({DEF, 1'b0}, ack);
      send_byte(8'h01, ack);
      send_bits(8'hFF, 5);
      write_word(DEF, 8'h60, 16'h0F0F, ok);
      chk(ok && we_cnt == n0 + 1, "R9 restart one write", we_cnt, n0 + 1);
      read_word(DEF, 8'h01, d, ok);
      chk(d == 16'h0001, "R9 reg untouched", {16'b0, d}, 32'h0001);
      read_word(DEF, 8'h60, d, ok);
      chk(d == 16'h0F0F, "R9 later write", {16'b0, d}, 32'h0F0F);

      // R4: standby masks bit 10 only
      standby = 1'b1;
      write_word(DEF, 8'h0D, 16'h16A5, ok);
      chk(mem[8'h0D] == 16'h12A5, "R4 bus data masked", {16'b0, mem[8'h0D]}, 32'h12A5);
      read_word(DEF, 8'h0D, d, ok);
      chk(ok && d == 16'h12A5, "R4 readback", {15'b0, ok, d}, 32'h1_12A5);
      probe(ALT, ack);
      chk(ack == 1'b0, "R4 alt still nack", {31'b0, ack}, 32'h0);

      // R3: standby low, select bit switches address
      standby = 1'b0;
      write_word(DEF, 8'h0D, 16'h16A5, ok);
      chk(ok, "R3 write acks", {31'b0, ok}, 32'h1);
      probe(DEF, ack);
      chk(ack == 1'b0, "R3 def nack", {31'b0, ack}, 32'h0);
      read_word(ALT, 8'h0D, d, ok);
      chk(ok && d == 16'h16A5, "R3 alt readback", {15'b0, ok, d}, 32'h1_16A5);

      // R8: page register
      n0 = we_cnt;
      write_word(ALT, 8'hF0, 16'hFFFD, ok);
      chk(we_cnt == n0, "R8 no strobe", we_cnt, n0);
      chk(bus_page == 3'd5, "R8 bus_page", {29'b0, bus_page}, 32'h5);
      read_word(ALT, 8'hF0, d, ok);
      chk(d == 16'h0005, "R8 read page", {16'b0, d}, 32'h5);
      write_word(ALT, 8'h30, 16'hBEEF, ok);
      chk(last_page == 3'd5 && mem[8'h30] == 16'hBEEF, "R8 page on write",
          {13'b0, last_page, mem[8'h30]}, 32'h5_BEEF);

      // R10: line released when idle
      repeat (4) @(negedge clk);
      chk(sda_oe == 1'b0, "R10 idle released", {31'b0, sda_oe}, 32'h0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule